// File: doc/BRIEF.md
# Queue-Relative Context Save and Restore Sequencer

This block moves a processor's trap context to and from a small context memory. The context consists of a 2-bit current-queue selector, the address registers of four instruction queues, the address registers of two stack queues and four static registers. The data halves of the queues are never stored, because they refill from memory once their pointers are back in place. The context therefore fits in ten words.

A save latches the register snapshot and then streams ten words out of the write port. The current queue number rides in the two top bits of the instruction-pointer word. The other three instruction-queue pointers follow in an order rotated by the current queue, so the queue number needs no word of its own. A restore streams the same ten words back through the read port. It recovers the queue number from the first word and uses it to steer the rotated words back to their own queues. It presents the rebuilt registers on parallel load buses.

Both memory ports use valid/ready handshakes. A word is transferred on a rising clock edge where valid and ready are both high. While ready is low, the block holds valid, index and write data steady and waits without limit. On the read port, the memory drives `rd_data` for the presented `rd_idx` in the same cycle, and the block takes it on the handshake edge. The start strobes, `done` and `ld_valid` are plain single-cycle pins.

Top module: `ctx_swap_seq`

## Requirements
- R1: After reset, `wr_valid`, `rd_valid`, `done` and `ld_valid` are low, and all load buses are zero.
- R2: A `save_start` seen while idle starts a save in the next cycle. The save offers entries at indices 0 to 9 in that order, one per accepted handshake. While `wr_ready` is low, `wr_valid`, `wr_idx` and `wr_data` stay unchanged.
- R3: Entry 0 is the address register of queue CQ. Its bits [31:30] are replaced by the 2-bit CQ value.
- R4: Entries 1, 2 and 3 are the address registers of queues (CQ+1) mod 4, (CQ+2) mod 4 and (CQ+3) mod 4.
- R5: Entries 4 and 5 are stack-queue address registers 0 and 1. Entries 6 to 9 are static registers 0 to 3.
- R6: The snapshot buses are sampled on the edge that accepts `save_start`. Later changes on them have no effect on the words written.
- R7: A `restore_start` seen while idle starts a restore in the next cycle. The restore reads indices 0 to 9 in order, one per accepted handshake, and holds `rd_valid` and `rd_idx` while `rd_ready` is low.
- R8: On restore, `ld_cq` takes bits [31:30] of entry 0. Entry 0, with those bits cleared, goes to instruction queue `ld_cq`. Entry k (k = 1..3) goes to queue (`ld_cq`+k) mod 4. Entries 4 to 9 go to the stack and static registers in the R5 order.
- R9: `done` is high for exactly one cycle, the cycle after the handshake of entry 9. `ld_valid` is high in that same cycle for a restore and never otherwise.
- R10: A start strobe is accepted only while idle. Strobes during a sequence or in its `done` cycle are ignored. If both strobes arrive together while idle, the save is taken.
- R11: When instruction-queue pointers have bits [31:30] clear, a save followed by a restore from the same memory reproduces CQ and every saved register exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| save_start | input | 1 | Begin a save (idle only) |
| restore_start | input | 1 | Begin a restore (idle only) |
| snap_cq | input | 2 | Current-queue selector to save |
| snap_iq | input | 128 | Instruction-queue address registers, queue k at bits [32k+31:32k] |
| snap_sq | input | 64 | Stack-queue address registers, queue k at bits [32k+31:32k] |
| snap_sr | input | 128 | Static registers, register k at bits [32k+31:32k] |
| wr_valid | output | 1 | Write word offered |
| wr_ready | input | 1 | Memory accepts the write word |
| wr_idx | output | 4 | Context entry index being written |
| wr_data | output | 32 | Context word being written |
| rd_valid | output | 1 | Read of `rd_idx` requested |
| rd_ready | input | 1 | `rd_data` is valid for `rd_idx` |
| rd_idx | output | 4 | Context entry index being read |
| rd_data | input | 32 | Context word returned |
| ld_valid | output | 1 | One-cycle pulse: load buses hold a restored context |
| ld_cq | output | 2 | Restored current-queue selector |
| ld_iq | output | 128 | Restored instruction-queue address registers |
| ld_sq | output | 64 | Restored stack-queue address registers |
| ld_sr | output | 128 | Restored static registers |
| done | output | 1 | One-cycle pulse at the end of a save or restore |

## Verification
The embedded properties watch the handshake and sequencing rules on every cycle. They check that the write and read ports are never both active, that an offer stalled by low ready keeps its index and word, and that the index advances by one per transfer. They also check that `done` is a single pulse following the entry-9 transfer, and that a restored entry 0 sets the queue number and clears the tag bits in the selected queue. Only the bench's scenarios can show the actual word placement. This covers the rotation for each of the four CQ values, snapshot isolation after the start edge, rejection of stray and simultaneous strobes, and an exact round trip of a full context, all under steady, alternating and random back-pressure.

// File: rtl/ctx_swap_pkg.sv
package ctx_swap_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_SAVE = 2'd1,
    SEQ_LOAD = 2'd2,
    SEQ_FIN  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/ctx_seq_ctrl.sv
module ctx_seq_ctrl
  import ctx_swap_pkg::*;
#(
  parameter int DEPTH = 10,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             save_start,
  input  logic             restore_start,
  input  logic             wr_ready,
  input  logic             rd_ready,
  output seq_state_e       state,
  output logic [IDX_W-1:0] idx,
  output logic             capture,
  output logic             wr_step,
  output logic             rd_step,
  output logic             done,
  output logic             done_load
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  seq_state_e       st_q;
  logic [IDX_W-1:0] idx_q;
  logic             load_q;
  logic             last;

  assign capture = (st_q == SEQ_IDLE) && save_start;
  assign wr_step = (st_q == SEQ_SAVE) && wr_ready;
  assign rd_step = (st_q == SEQ_LOAD) && rd_ready;
  assign last    = (idx_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      idx_q  <= '0;
      load_q <= 1'b0;
    end else begin
      case (st_q)
        SEQ_IDLE: begin
          idx_q <= '0;
          if (save_start) begin
            st_q   <= SEQ_SAVE;
            load_q <= 1'b0;
          end else if (restore_start) begin
            st_q   <= SEQ_LOAD;
            load_q <= 1'b1;
          end
        end
        SEQ_SAVE, SEQ_LOAD: begin
          if (wr_step || rd_step) begin
            if (last) st_q <= SEQ_FIN;
            else      idx_q <= idx_q + IDX_W'(1);
          end
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign state     = st_q;
  assign idx       = idx_q;
  assign done      = (st_q == SEQ_FIN);
  assign done_load = (st_q == SEQ_FIN) && load_q;

  p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST);
  p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_step || rd_step) && !last) |=> (idx_q == $past(idx_q) + IDX_W'(1)));
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == SEQ_LOAD) && !rd_ready) |=> ((st_q == SEQ_LOAD) && $stable(idx_q)));
  p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_step || rd_step) && last) |=> done);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == SEQ_SAVE) && !wr_ready) |=> (st_q == SEQ_SAVE));
endmodule

// File: rtl/ctx_pack.sv
module ctx_pack #(
  parameter int DATA_W   = 32,
  parameter int CQ_W     = 2,
  parameter int N_STACK  = 2,
  parameter int N_STATIC = 4,
  parameter int IDX_W    = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         capture,
  input  logic [CQ_W-1:0]              snap_cq,
  input  logic [(1<<CQ_W)*DATA_W-1:0]  snap_iq,
  input  logic [N_STACK*DATA_W-1:0]    snap_sq,
  input  logic [N_STATIC*DATA_W-1:0]   snap_sr,
  input  logic [IDX_W-1:0]             idx,
  output logic [DATA_W-1:0]            word
);
  localparam int NIQ = 1 << CQ_W;

  logic [CQ_W-1:0]   cq_q;
  logic [DATA_W-1:0] iq_q [NIQ];
  logic [DATA_W-1:0] sq_q [N_STACK];
  logic [DATA_W-1:0] sr_q [N_STATIC];
  logic [CQ_W-1:0]   rot_sel [NIQ];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cq_q <= '0;
      for (int k = 0; k < NIQ; k++)      iq_q[k] <= '0;
      for (int k = 0; k < N_STACK; k++)  sq_q[k] <= '0;
      for (int k = 0; k < N_STATIC; k++) sr_q[k] <= '0;
    end else if (capture) begin
      cq_q <= snap_cq;
      for (int k = 0; k < NIQ; k++)      iq_q[k] <= snap_iq[k*DATA_W +: DATA_W];
      for (int k = 0; k < N_STACK; k++)  sq_q[k] <= snap_sq[k*DATA_W +: DATA_W];
      for (int k = 0; k < N_STATIC; k++) sr_q[k] <= snap_sr[k*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    for (int k = 0; k < NIQ; k++) rot_sel[k] = cq_q + CQ_W'(k);
  end

  always_comb begin
    word = '0;
    if (idx == '0) begin
      word = iq_q[cq_q];
      word[DATA_W-1 -: CQ_W] = cq_q;
    end
    for (int k = 1; k < NIQ; k++)
      if (idx == IDX_W'(k)) word = iq_q[rot_sel[k]];
    for (int k = 0; k < N_STACK; k++)
      if (idx == IDX_W'(NIQ + k)) word = sq_q[k];
    for (int k = 0; k < N_STATIC; k++)
      if (idx == IDX_W'(NIQ + N_STACK + k)) word = sr_q[k];
  end

  p_snapshot_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> ($stable(cq_q) && $stable(iq_q[0]) && $stable(sr_q[0])));
endmodule

// File: rtl/ctx_unpack.sv
module ctx_unpack #(
  parameter int DATA_W   = 32,
  parameter int CQ_W     = 2,
  parameter int N_STACK  = 2,
  parameter int N_STATIC = 4,
  parameter int IDX_W    = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         step,
  input  logic [IDX_W-1:0]             idx,
  input  logic [DATA_W-1:0]            rd_data,
  output logic [CQ_W-1:0]              ld_cq,
  output logic [(1<<CQ_W)*DATA_W-1:0]  ld_iq,
  output logic [N_STACK*DATA_W-1:0]    ld_sq,
  output logic [N_STATIC*DATA_W-1:0]   ld_sr
);
  localparam int NIQ = 1 << CQ_W;

  logic [CQ_W-1:0]   cq_q;
  logic [DATA_W-1:0] iq_q [NIQ];
  logic [DATA_W-1:0] sq_q [N_STACK];
  logic [DATA_W-1:0] sr_q [N_STATIC];
  logic [CQ_W-1:0]   rot_sel [NIQ];
  logic [CQ_W-1:0]   tag;
  logic [DATA_W-1:0] ip_clean;

  always_comb begin
    for (int k = 0; k < NIQ; k++) rot_sel[k] = cq_q + CQ_W'(k);
    tag = rd_data[DATA_W-1 -: CQ_W];
    ip_clean = rd_data;
    ip_clean[DATA_W-1 -: CQ_W] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cq_q <= '0;
      for (int k = 0; k < NIQ; k++)      iq_q[k] <= '0;
      for (int k = 0; k < N_STACK; k++)  sq_q[k] <= '0;
      for (int k = 0; k < N_STATIC; k++) sr_q[k] <= '0;
    end else if (step) begin
      if (idx == '0) begin
        cq_q      <= tag;
        iq_q[tag] <= ip_clean;
      end
      for (int k = 1; k < NIQ; k++)
        if (idx == IDX_W'(k)) iq_q[rot_sel[k]] <= rd_data;
      for (int k = 0; k < N_STACK; k++)
        if (idx == IDX_W'(NIQ + k)) sq_q[k] <= rd_data;
      for (int k = 0; k < N_STATIC; k++)
        if (idx == IDX_W'(NIQ + N_STACK + k)) sr_q[k] <= rd_data;
    end
  end

  assign ld_cq = cq_q;
  for (genvar g = 0; g < NIQ; g++) begin : g_iq
    assign ld_iq[g*DATA_W +: DATA_W] = iq_q[g];
  end
  for (genvar g = 0; g < N_STACK; g++) begin : g_sq
    assign ld_sq[g*DATA_W +: DATA_W] = sq_q[g];
  end
  for (genvar g = 0; g < N_STATIC; g++) begin : g_sr
    assign ld_sr[g*DATA_W +: DATA_W] = sr_q[g];
  end

  p_cq_from_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && idx == '0) |=> (cq_q == $past(rd_data[DATA_W-1 -: CQ_W])));
  p_ip_untagged_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && idx == '0) |=> (iq_q[cq_q][DATA_W-1 -: CQ_W] == '0));
endmodule

// File: rtl/ctx_swap_seq.sv
module ctx_swap_seq
  import ctx_swap_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CQ_W     = 2,
  parameter int N_STACK  = 2,
  parameter int N_STATIC = 4,
  localparam int NIQ     = 1 << CQ_W,
  localparam int DEPTH   = NIQ + N_STACK + N_STATIC,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       save_start,
  input  logic                       restore_start,
  input  logic [CQ_W-1:0]            snap_cq,
  input  logic [NIQ*DATA_W-1:0]      snap_iq,
  input  logic [N_STACK*DATA_W-1:0]  snap_sq,
  input  logic [N_STATIC*DATA_W-1:0] snap_sr,
  output logic                       wr_valid,
  input  logic                       wr_ready,
  output logic [IDX_W-1:0]           wr_idx,
  output logic [DATA_W-1:0]          wr_data,
  output logic                       rd_valid,
  input  logic                       rd_ready,
  output logic [IDX_W-1:0]           rd_idx,
  input  logic [DATA_W-1:0]          rd_data,
  output logic                       ld_valid,
  output logic [CQ_W-1:0]            ld_cq,
  output logic [NIQ*DATA_W-1:0]      ld_iq,
  output logic [N_STACK*DATA_W-1:0]  ld_sq,
  output logic [N_STATIC*DATA_W-1:0] ld_sr,
  output logic                       done
);
  seq_state_e       state;
  logic [IDX_W-1:0] idx;
  logic             capture, wr_step, rd_step;

  ctx_seq_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .save_start(save_start), .restore_start(restore_start),
    .wr_ready(wr_ready), .rd_ready(rd_ready),
    .state(state), .idx(idx), .capture(capture),
    .wr_step(wr_step), .rd_step(rd_step),
    .done(done), .done_load(ld_valid)
  );

  ctx_pack #(.DATA_W(DATA_W), .CQ_W(CQ_W), .N_STACK(N_STACK),
             .N_STATIC(N_STATIC), .IDX_W(IDX_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .capture(capture),
    .snap_cq(snap_cq), .snap_iq(snap_iq), .snap_sq(snap_sq), .snap_sr(snap_sr),
    .idx(idx), .word(wr_data)
  );

  ctx_unpack #(.DATA_W(DATA_W), .CQ_W(CQ_W), .N_STACK(N_STACK),
               .N_STATIC(N_STATIC), .IDX_W(IDX_W)) u_unpack (
    .clk(clk), .rst_n(rst_n), .step(rd_step), .idx(idx), .rd_data(rd_data),
    .ld_cq(ld_cq), .ld_iq(ld_iq), .ld_sq(ld_sq), .ld_sr(ld_sr)
  );

  assign wr_valid = (state == SEQ_SAVE);
  assign rd_valid = (state == SEQ_LOAD);
  assign wr_idx   = idx;
  assign rd_idx   = idx;

  p_port_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && rd_valid));
  p_wr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_idx) && $stable(wr_data)));
  p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_idx)));
  p_ld_only_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> done);
endmodule

// File: tb/sim_ctx_swap_seq.sv
module sim_ctx_swap_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         rst_n, save_start, restore_start, wr_ready, rd_ready;
  logic [1:0]   snap_cq, ld_cq;
  logic [127:0] snap_iq, snap_sr, ld_iq, ld_sr;
  logic [63:0]  snap_sq, ld_sq;
  logic         wr_valid, rd_valid, ld_valid, done;
  logic [3:0]   wr_idx, rd_idx;
  logic [31:0]  wr_data, rd_data;
  logic [31:0]  mem [10];

  assign rd_data = (rd_idx < 4'd10) ? mem[rd_idx] : 32'h0;

  ctx_swap_seq u0 (
    .clk(clk), .rst_n(rst_n), .save_start(save_start), .restore_start(restore_start),
    .snap_cq(snap_cq), .snap_iq(snap_iq), .snap_sq(snap_sq), .snap_sr(snap_sr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_idx(rd_idx), .rd_data(rd_data),
    .ld_valid(ld_valid), .ld_cq(ld_cq), .ld_iq(ld_iq), .ld_sq(ld_sq), .ld_sr(ld_sr),
    .done(done)
  );

  int checks = 0, fails = 0;
  // reference model: 0 idle, 1 saving, 2 restoring, 3 done cycle
  int m_st = 0, m_idx = 0, ready_mode = 0, tog = 0;
  bit m_ld = 0, cap_pend = 0, rt_on = 0;
  bit [1:0]  m_cq, e_cq, r_cq;
  bit [31:0] m_iq[4], m_sq[2], m_sr[4];
  bit [31:0] e_iq[4], e_sq[2], e_sr[4];
  bit [31:0] r_iq[4], r_sq[2], r_sr[4];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit [31:0] exp_word(int i);
    if (i == 0) return {m_cq, m_iq[m_cq][29:0]};
    if (i < 4)  return m_iq[(int'(m_cq) + i) % 4];
    if (i < 6)  return m_sq[i-4];
    return m_sr[i-6];
  endfunction

  function automatic string word_req(int i);
    if (i == 0) return "R3";
    if (i < 4)  return "R4";
    return "R5";
  endfunction

  task automatic set_snap(bit [1:0] cq);
    snap_cq = cq;
    for (int k = 0; k < 4; k++) snap_iq[k*32 +: 32] = $urandom() & 32'h3fff_ffff;
    for (int k = 0; k < 2; k++) snap_sq[k*32 +: 32] = $urandom();
    for (int k = 0; k < 4; k++) snap_sr[k*32 +: 32] = $urandom();
  endtask

  task automatic tick(bit s, bit r);
    @(negedge clk);
    if (cap_pend) begin  // values present at the accepting edge
      m_cq = snap_cq;
      for (int k = 0; k < 4; k++) m_iq[k] = snap_iq[k*32 +: 32];
      for (int k = 0; k < 2; k++) m_sq[k] = snap_sq[k*32 +: 32];
      for (int k = 0; k < 4; k++) m_sr[k] = snap_sr[k*32 +: 32];
      r_cq = m_cq; r_iq = m_iq; r_sq = m_sq; r_sr = m_sr;
      cap_pend = 0;
    end
    chk("R2 wr_valid", wr_valid, m_st == 1);
    chk("R7 rd_valid", rd_valid, m_st == 2);
    chk("R9 done", done, m_st == 3);
    chk("R9 ld_valid", ld_valid, (m_st == 3) && m_ld);
    if (m_st == 1) begin
      chk("R2 wr_idx", wr_idx, m_idx);
      chk({word_req(m_idx), " R6 wr_data"}, wr_data, exp_word(m_idx));
    end
    if (m_st == 2) chk("R7 rd_idx", rd_idx, m_idx);
    if (m_st == 3 && m_ld) begin
      chk("R8 ld_cq", ld_cq, e_cq);
      for (int k = 0; k < 4; k++) chk("R8 ld_iq", ld_iq[k*32 +: 32], e_iq[k]);
      for (int k = 0; k < 2; k++) chk("R8 ld_sq", ld_sq[k*32 +: 32], e_sq[k]);
      for (int k = 0; k < 4; k++) chk("R8 ld_sr", ld_sr[k*32 +: 32], e_sr[k]);
      if (rt_on) begin
        chk("R11 cq", ld_cq, r_cq);
        for (int k = 0; k < 4; k++) chk("R11 iq", ld_iq[k*32 +: 32], r_iq[k]);
        for (int k = 0; k < 2; k++) chk("R11 sq", ld_sq[k*32 +: 32], r_sq[k]);
        for (int k = 0; k < 4; k++) chk("R11 sr", ld_sr[k*32 +: 32], r_sr[k]);
      end
    end
    // drive this cycle's inputs
    save_start = s; restore_start = r; tog++;
    case (ready_mode)
      0: begin wr_ready = 1; rd_ready = 1; end
      1: begin wr_ready = tog[0]; rd_ready = ~tog[0]; end
      default: begin wr_ready = $urandom() % 2; rd_ready = $urandom() % 2; end
    endcase
    // advance the model across the coming edge
    case (m_st)
      0: if (s) begin m_st = 1; m_idx = 0; m_ld = 0; cap_pend = 1; end
         else if (r) begin m_st = 2; m_idx = 0; m_ld = 1; end
      1: if (wr_ready) begin
           mem[m_idx] = exp_word(m_idx);
           if (m_idx == 9) m_st = 3; else m_idx++;
         end
      2: if (rd_ready) begin
           if (m_idx == 0) begin e_cq = mem[0][31:30]; e_iq[e_cq] = mem[0] & 32'h3fff_ffff; end
           else if (m_idx < 4) e_iq[(int'(e_cq) + m_idx) % 4] = mem[m_idx];
           else if (m_idx < 6) e_sq[m_idx-4] = mem[m_idx];
           else e_sr[m_idx-6] = mem[m_idx];
           if (m_idx == 9) m_st = 3; else m_idx++;
         end
      default: m_st = 0;
    endcase
  endtask

  // start one sequence, throw stray strobes at it (R10), run it to idle
  task automatic run(bit is_save, bit both);
    int n = 0;
    tick(is_save | both, !is_save | both);
    while (m_st != 0 && n < 400) begin
      n++;
      tick((n == 3) || (m_st == 3), (n == 5) || (m_st == 3));
      if (n == 2 && is_save) set_snap(~snap_cq);  // R6: change after capture
    end
    tick(0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 10; k++) mem[k] = '0;
    for (int k = 0; k < 4; k++) begin e_iq[k] = 0; e_sr[k] = 0; end
    e_sq[0] = 0; e_sq[1] = 0; e_cq = 0;
    rst_n = 0; save_start = 0; restore_start = 0; wr_ready = 0; rd_ready = 0;
    set_snap(2'd0);
    tick(0, 0); tick(0, 0);
    rst_n = 1;
    tick(0, 0);
    // R1: reset state
    chk("R1 ld_cq", ld_cq, 0);
    chk("R1 ld_iq", ld_iq[31:0], 0);
    chk("R1 ld_sr", ld_sr[127:96], 0);
    chk("R1 idle", {wr_valid, rd_valid, done, ld_valid}, 0);
    for (int c = 0; c < 4; c++) begin
      ready_mode = c % 3;
      set_snap(2'(c));
      rt_on = 0;
      run(1, c == 2);  // c==2: simultaneous strobes, save must win (R10)
      rt_on = 1;
      ready_mode = (c + 1) % 3;
      run(0, 0);
      rt_on = 0;
    end
    // restore from a hand-built image with tagged IP (R8)
    ready_mode = 2;
    mem[0] = 32'hC123_4567;
    for (int k = 1; k < 10; k++) mem[k] = 32'h1000_0000 * k + k;
    run(0, 0);
    chk("R8 final cq", ld_cq, 2'd3);
    chk("R8 final ip", ld_iq[3*32 +: 32], 32'h0123_4567);
    chk("R8 rotated q0", ld_iq[31:0], 32'h1000_0001);
    chk("R8 rotated q2", ld_iq[2*32 +: 32], 32'h3000_0003);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule